// File: doc/BRIEF.md
# Tone Steering Guard Validator

This block sits behind a dual-tone decoder and does the duration checks that used to need an external RC steering network. The decoder supplies a presence flag, which is high while it sees a valid tone pair, and a 4-bit digit code. Two counters, driven by a slow timebase tick (nominally 1 ms), decide when a tone is real. The tone must stay present for a programmable acquisition guard. After that, the silence must last for a programmable release guard before the digit is considered finished.

When the acquisition guard expires, the current code is captured into a holding register and the guard output goes high. A fixed settling delay of two clock cycles later, the data-valid flag rises and the code appears on the receive data output. That output changes only at this moment. Short dropouts inside a tone are bridged. A second digit can only be accepted once a full pause has been validated. An active-low interrupt follows a pending-data request. The request is set when data-valid rises and is cleared either by a read strobe or by the end of the digit.

Top module: `tone_guard_validator`

## Requirements
- R1: After synchronous reset, gt_out and dv_out are 0, irq_n is 1 and rx_data is 0.
- R2: If tone_present stays high continuously for acq_guard ticks, the pair is registered and gt_out rises. The first edge with tone_present high and the registration edge are between (acq_guard-1) and (acq_guard+1) tick periods apart, plus one cycle.
- R3: A presence burst that ends before acq_guard ticks have been counted registers nothing. gt_out and dv_out stay 0.
- R4: The code captured is the value of tone_code at the clock edge where gt_out rises. Later changes of tone_code do not affect it.
- R5: dv_out rises exactly 2 clock cycles after gt_out rises. rx_data takes the captured code at that same edge and changes at no other edge.
- R6: Once registered, gt_out stays high while tone_present is high. A low period of tone_present shorter than rel_guard ticks leaves gt_out, dv_out and rx_data unchanged.
- R7: When tone_present has stayed low for rel_guard ticks after registration, gt_out and dv_out fall together at the same edge.
- R8: No new pair is registered until a pause has been validated. A tone that resumes after a short dropout with a different code does not change rx_data and produces no new dv_out rising edge.
- R9: irq_n is low only while an interrupt request is pending and irq_en is high. Changing irq_en takes effect at the next clock edge.
- R10: A one-cycle rd_strobe clears the pending request, so irq_n is high after that edge while dv_out stays high. If the read arrives at the same edge as a dv_out rise, the new request wins.
- R11: The pending request is also cleared when dv_out falls at the end of a validated pause.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-cycle timebase pulse (guard time unit) |
| tone_present | input | 1 | Early presence flag from the decoder |
| tone_code | input | CODE_W | Digit code from the decoder |
| acq_guard | input | GUARD_W | Acquisition guard, in ticks |
| rel_guard | input | GUARD_W | Release guard, in ticks |
| irq_en | input | 1 | Interrupt enable |
| rd_strobe | input | 1 | One-cycle read of the receive data register |
| rx_data | output | CODE_W | Receive data register |
| gt_out | output | 1 | Guard-time output, high from registration until the pause is validated |
| dv_out | output | 1 | Delayed data-valid flag |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
A wrong phase or a miscounting guard timer shows up on gt_out within one tick period of the expected edge. The gap from gt_out to dv_out then exposes any error in the settling pipeline to the exact cycle. A holding register loaded at the wrong edge shows up as a wrong rx_data value on the next dv_out rise, and the scoreboard compares every such rise with the expected digit. A stuck or badly cleared request flag is seen on irq_n one edge after the read, the enable change or the end of the pause that should have moved it.

// File: rtl/tgv_pkg.sv
package tgv_pkg;
  typedef enum logic [1:0] {
    TGV_IDLE   = 2'd0,
    TGV_SETTLE = 2'd1,
    TGV_HELD   = 2'd2
  } tgv_phase_e;
endpackage

// File: rtl/tgv_guard_timer.sv
module tgv_guard_timer #(
  parameter int GUARD_W = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               run,
  input  logic               tick,
  input  logic [GUARD_W-1:0] limit,
  output logic               done
);
  logic [GUARD_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt <= '0;
    end else if (tick && (cnt != limit)) begin
      cnt <= cnt + 1'b1;
    end
  end

  // done means: the condition held continuously for limit ticks
  assign done = run && (cnt == limit);
endmodule

// File: rtl/tgv_settle_delay.sv
module tgv_settle_delay #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pulse_in,
  output logic pulse_out
);
  logic [STAGES-1:0] pipe;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (rst) pipe <= '0;
        else     pipe <= pulse_in;
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (rst) pipe <= '0;
        else     pipe <= {pipe[STAGES-2:0], pulse_in};
      end
    end
  endgenerate

  assign pulse_out = pipe[STAGES-1];
endmodule

// File: rtl/tgv_irq_ctrl.sv
module tgv_irq_ctrl (
  input  logic clk,
  input  logic rst,
  input  logic set_req,
  input  logic clr_end,
  input  logic rd_strobe,
  input  logic irq_en,
  output logic irq_n
);
  logic pend, pend_nxt;

  always_comb begin
    if (set_req)                  pend_nxt = 1'b1;
    else if (rd_strobe || clr_end) pend_nxt = 1'b0;
    else                          pend_nxt = pend;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend  <= 1'b0;
      irq_n <= 1'b1;
    end else begin
      pend  <= pend_nxt;
      irq_n <= ~(irq_en & pend_nxt);
    end
  end
endmodule

// File: rtl/tone_guard_validator.sv
module tone_guard_validator
  import tgv_pkg::*;
#(
  parameter int CODE_W  = 4,
  parameter int GUARD_W = 8,
  parameter int SETTLE  = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               tick,
  input  logic               tone_present,
  input  logic [CODE_W-1:0]  tone_code,
  input  logic [GUARD_W-1:0] acq_guard,
  input  logic [GUARD_W-1:0] rel_guard,
  input  logic               irq_en,
  input  logic               rd_strobe,
  output logic [CODE_W-1:0]  rx_data,
  output logic               gt_out,
  output logic               dv_out,
  output logic               irq_n
);
  tgv_phase_e phase;
  logic [CODE_W-1:0] hold_code;
  logic acq_run, acq_done, rel_run, rel_done;
  logic latch_ev, settle_ev, dv_set, dv_clr;

  assign acq_run  = (phase == TGV_IDLE) && tone_present;
  assign rel_run  = (phase == TGV_HELD) && !tone_present;
  assign latch_ev = (phase == TGV_IDLE) && acq_done;
  assign dv_set   = (phase == TGV_SETTLE) && settle_ev;
  assign dv_clr   = (phase == TGV_HELD) && rel_done;

  tgv_guard_timer #(.GUARD_W(GUARD_W)) acq_tmr_i (
    .clk(clk), .rst(rst), .run(acq_run), .tick(tick),
    .limit(acq_guard), .done(acq_done));

  tgv_guard_timer #(.GUARD_W(GUARD_W)) rel_tmr_i (
    .clk(clk), .rst(rst), .run(rel_run), .tick(tick),
    .limit(rel_guard), .done(rel_done));

  tgv_settle_delay #(.STAGES(SETTLE)) settle_i (
    .clk(clk), .rst(rst), .pulse_in(latch_ev), .pulse_out(settle_ev));

  tgv_irq_ctrl irq_i (
    .clk(clk), .rst(rst), .set_req(dv_set), .clr_end(dv_clr),
    .rd_strobe(rd_strobe), .irq_en(irq_en), .irq_n(irq_n));

  always_ff @(posedge clk) begin
    if (rst) begin
      phase     <= TGV_IDLE;
      hold_code <= '0;
      rx_data   <= '0;
      gt_out    <= 1'b0;
      dv_out    <= 1'b0;
    end else begin
      unique case (phase)
        TGV_IDLE: if (acq_done) begin
          hold_code <= tone_code;
          gt_out    <= 1'b1;
          phase     <= TGV_SETTLE;
        end
        TGV_SETTLE: if (settle_ev) begin
          dv_out  <= 1'b1;
          rx_data <= hold_code;
          phase   <= TGV_HELD;
        end
        TGV_HELD: if (rel_done) begin
          gt_out <= 1'b0;
          dv_out <= 1'b0;
          phase  <= TGV_IDLE;
        end
        default: phase <= TGV_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/tgv_checker.sv
module tgv_checker #(
  parameter int CODE_W = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              tone_present,
  input logic              rd_strobe,
  input logic [CODE_W-1:0] rx_data,
  input logic              gt_out,
  input logic              dv_out,
  input logic              irq_n
);
  assert_gt_needs_tone_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(gt_out) |-> $past(tone_present));

  assert_dv_two_after_gt_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(gt_out) |-> ##2 $rose(dv_out));

  assert_rx_only_on_dv_R5: assert property (@(posedge clk) disable iff (rst)
    !$rose(dv_out) |-> $stable(rx_data));

  assert_gt_holds_R6: assert property (@(posedge clk) disable iff (rst)
    (gt_out && tone_present) |=> gt_out);

  assert_fall_together_R7: assert property (@(posedge clk) disable iff (rst)
    $fell(gt_out) |-> ($fell(dv_out) && !$past(tone_present)));

  assert_irq_needs_dv_R9: assert property (@(posedge clk) disable iff (rst)
    !irq_n |-> dv_out);

  assert_read_clears_R10: assert property (@(posedge clk) disable iff (rst)
    ($past(rd_strobe) && !$rose(dv_out)) |-> irq_n);
endmodule

bind tone_guard_validator tgv_checker #(.CODE_W(CODE_W)) chk_i (
  .clk(clk), .rst(rst), .tone_present(tone_present), .rd_strobe(rd_strobe),
  .rx_data(rx_data), .gt_out(gt_out), .dv_out(dv_out), .irq_n(irq_n));

// File: tb/tone_guard_validator_tb_top.sv
module tone_guard_validator_tb_top;
  localparam int CW = 4;
  localparam int GW = 8;
  localparam int TP = 4;
  localparam int ACQ = 5;
  localparam int REL = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick = 1'b0;
  logic tone_present = 1'b0;
  logic [CW-1:0] tone_code = '0;
  logic [GW-1:0] acq_guard = GW'(ACQ);
  logic [GW-1:0] rel_guard = GW'(REL);
  logic irq_en = 1'b1;
  logic rd_strobe = 1'b0;
  logic [CW-1:0] rx_data;
  logic gt_out, dv_out, irq_n;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  int tone_start = 0;
  logic [CW-1:0] exp_q[$];

  always #2 clk = ~clk;

  tone_guard_validator #(.CODE_W(CW), .GUARD_W(GW), .SETTLE(2)) dut_i (
    .clk(clk), .rst(rst), .tick(tick), .tone_present(tone_present),
    .tone_code(tone_code), .acq_guard(acq_guard), .rel_guard(rel_guard),
    .irq_en(irq_en), .rd_strobe(rd_strobe), .rx_data(rx_data),
    .gt_out(gt_out), .dv_out(dv_out), .irq_n(irq_n));

  always @(posedge clk) begin
    cyc <= cyc + 1;
    tick <= ((cyc % TP) == TP - 1);
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Scoreboard monitor
  logic prev_gt = 1'b0, prev_dv = 1'b0;
  logic [CW-1:0] prev_rx = '0;
  int gt_rise_cyc = 0;
  always @(negedge clk) begin
    if (!rst) begin
      if (gt_out && !prev_gt) begin
        gt_rise_cyc = cyc;
        check("R2 acq window", int'((cyc - tone_start) >= (ACQ-1)*TP &&
              (cyc - tone_start) <= (ACQ+1)*TP + 1), 1);
      end
      if (dv_out && !prev_dv) begin
        check("R5 settle delay", cyc - gt_rise_cyc, 2);
        if (exp_q.size() == 0) begin
          check("R8 unexpected registration", 1, 0);
        end else begin
          check("R4 code", int'(rx_data), int'(exp_q.pop_front()));
        end
      end else if (rx_data != prev_rx) begin
        check("R5 rx changed without dv rise", int'(rx_data), int'(prev_rx));
      end
    end
    prev_gt = gt_out;
    prev_dv = dv_out;
    prev_rx = rx_data;
  end

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic tone(input logic [CW-1:0] c, input int len, input bit expect_reg);
    tone_code = c;
    tone_present = 1'b1;
    tone_start = cyc;
    if (expect_reg) exp_q.push_back(c);
    cycles(len);
    tone_present = 1'b0;
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    cycles(4);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check("R1 gt", int'(gt_out), 0);
    check("R1 dv", int'(dv_out), 0);
    check("R1 irq_n", int'(irq_n), 1);
    check("R1 rx", int'(rx_data), 0);

    // R2/R7 basic digit then pause
    tone(4'd1, 40, 1'b1);
    check("R6 gt held during tone", int'(gt_out), 1);
    cycles(30);
    check("R7 gt after pause", int'(gt_out), 0);
    check("R7 dv after pause", int'(dv_out), 0);
    check("R11 irq after pause", int'(irq_n), 1);

    // R3 short burst rejected
    tone(4'd6, 12, 1'b0);
    cycles(2);
    check("R3 gt", int'(gt_out), 0);
    check("R3 dv", int'(dv_out), 0);
    cycles(20);

    // R4 code captured at expiry, later change ignored
    tone_code = 4'd9;
    tone_present = 1'b1;
    tone_start = cyc;
    exp_q.push_back(4'd9);
    while (!gt_out) @(negedge clk);
    tone_code = 4'd4;
    while (!dv_out) @(negedge clk);
    tone_code = 4'd7;
    cycles(3);
    check("R5 rx stable", int'(rx_data), 9);
    cycles(10);
    tone_present = 1'b0;
    cycles(30);

    // R6/R8 dropout bridged, resumed tone with new code ignored
    tone(4'hA, 40, 1'b1);
    cycles(5);
    check("R6 dv over dropout", int'(dv_out), 1);
    check("R6 gt over dropout", int'(gt_out), 1);
    tone(4'd3, 40, 1'b0);
    check("R8 rx unchanged", int'(rx_data), 10);
    cycles(30);
    check("R7 released", int'(dv_out), 0);

    // R9/R10 interrupt and read
    tone(4'd5, 40, 1'b1);
    check("R9 irq asserted", int'(irq_n), 0);
    rd_strobe = 1'b1;
    @(negedge clk);
    rd_strobe = 1'b0;
    check("R10 irq cleared", int'(irq_n), 1);
    check("R10 dv kept", int'(dv_out), 1);
    cycles(30);

    // R9/R11 enable gating and release on pause
    irq_en = 1'b0;
    tone(4'd12, 40, 1'b1);
    check("R9 irq masked", int'(irq_n), 1);
    irq_en = 1'b1;
    @(negedge clk);
    check("R9 irq after enable", int'(irq_n), 0);
    cycles(30);
    check("R11 irq released", int'(irq_n), 1);

    // R10 read at the same edge as dv rise: request wins
    tone_code = 4'd15;
    tone_present = 1'b1;
    tone_start = cyc;
    exp_q.push_back(4'd15);
    while (!gt_out) @(negedge clk);
    @(negedge clk);
    rd_strobe = 1'b1;
    @(negedge clk);
    rd_strobe = 1'b0;
    check("R10 rise wins over read", int'(irq_n), 0);
    cycles(10);
    tone_present = 1'b0;
    cycles(30);

    // Back-to-back digits
    for (int i = 0; i < 4; i++) begin
      tone(CW'(i * 5 + 2), 30, 1'b1);
      cycles(25);
    end
    check("R2 all digits registered", exp_q.size(), 0);
    finish_run();
  end
endmodule